// File: doc/BRIEF.md
# Synchronous Buck Gate Control Core

This block is the clocked decision logic behind a half-bridge driver for a synchronous buck converter. A controller supplies a three-level pulse command as a 2-bit code. The block turns that command into separate gate requests for the high-side and low-side switches, and it never lets the two overlap. Pulses that are too short are suppressed. Every high-side on period is followed by an enforced off interval. All durations are counted in clock cycles and set by parameters.

Two validity flags, for enable and for supply, gate the whole output stage. Two comparator flags, for over-temperature and for low-side over-current, feed a sticky fault indicator. The over-current flag is looked at only at the current valley, which is the moment the low-side switch is released for a new high pulse. The fault indicator never interrupts switching. Only a loss of enable or supply clears it. Every asynchronous input passes through a synchronizer of `SYNC_STAGES` flops before it is used.

Top module: `buck_gate_ctrl`

## Requirements
- R1: Command code 2'b10 requests the high side on and the low side off. Code 2'b00 requests the low side on and the high side off. Codes 2'b01 and 2'b11 request both switches off. In steady state the gates match these requests for every pair of successive codes.
- R2: While enable or supply is invalid, both gates are off. A drop in either flag turns the gates off on the third clock edge after the input changes. Switching resumes once both flags are valid again.
- R3: The two gates are never on in the same cycle. Before either gate turns on, both gates have been off for at least `DEAD_CYC` cycles. A high-to-low command change gives a gap of exactly `DEAD_CYC` cycles.
- R4: A high command lasting W cycles gives no high-side on time when W < `MIN_ON_CYC`. Otherwise it gives exactly W − `MIN_ON_CYC` + 1 on cycles, provided it follows a long low period.
- R5: Between two high-side on periods the gate stays off for max(L + `MIN_ON_CYC` − 1, `MIN_OFF_CYC`) cycles, where L is the number of cycles the command left the high code.
- R6: Over-current is sampled only in the cycle after the low-side gate is released while the command is high. An asserted over-current flag has no effect while the command stays low, or when a high command follows a mid command.
- R7: A sampled over-current sets the fault only when the over-current enable is 1. Over-temperature sets the fault whatever the enable is.
- R8: Once set, the fault stays set while enable and supply stay valid, even after the cause ends or the over-current enable toggles.
- R9: While enable or supply is invalid, the fault output is 0 and the fault cannot be set, even with a cause present. After validity returns, a cause that is still present sets it again.
- R10: With the fault set, the gate outputs keep following the command with the same timing as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_code | input | 2 | Three-level pulse command (00 low, 01/11 mid, 10 high) |
| en_ok | input | 1 | Enable above threshold |
| vcc_ok | input | 1 | Driver supply above undervoltage threshold |
| ot_flag | input | 1 | Over-temperature comparator output |
| oc_flag | input | 1 | Low-side over-current comparator output |
| oc_en | input | 1 | Allows over-current to set the fault |
| hs_gate | output | 1 | High-side gate request |
| ls_gate | output | 1 | Low-side gate request |
| fault | output | 1 | Latched fault indicator, active high |

## Verification
Two things can happen in the same cycle: the fault latch being set and the fault latch being cleared by lost validity. The bench forces them together by holding over-temperature high while supply or enable is invalid. It expects the fault to stay 0 through that whole window and to rise only once validity returns while the cause is still present. The same collision is judged a second time when enable drops while a set fault is active: the output must read 0 within the synchronizer delay. A second overlap occurs when a qualified high request meets an unexpired off interval. The bench sweeps the low-gap length around the `MIN_OFF_CYC` boundary and compares the measured gap against the larger of the two limits.

// File: rtl/buck_ctrl_pkg.sv
package buck_ctrl_pkg;

   typedef enum logic [1:0] {
      LVL_LO  = 2'b00,
      LVL_MID = 2'b01,
      LVL_HI  = 2'b10
   } lvl_e;

   typedef enum logic [1:0] {
      DRV_OFF = 2'b00,
      DRV_HI  = 2'b01,
      DRV_LO  = 2'b10
   } drive_e;

   // 2'b11 is folded onto the mid level
   function automatic lvl_e decode_lvl(input logic [1:0] code);
      case (code)
         2'b00:   return LVL_LO;
         2'b10:   return LVL_HI;
         default: return LVL_MID;
      endcase
   endfunction

endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/bgc_satcnt.sv
module bgc_satcnt #(
   parameter int unsigned MAX        = 3,
   parameter bit          RST_AT_MAX = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic at_max
);

   localparam int unsigned CW  = (MAX < 1) ? 1 : $clog2(MAX + 1);
   localparam logic [CW-1:0] LIM = CW'(MAX);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= RST_AT_MAX ? LIM : '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (cnt != LIM) begin
         cnt <= cnt + CW'(1);
      end
   end

   assign at_max = (cnt == LIM);

endmodule

// File: rtl/bgc_shaper.sv
module bgc_shaper
   import buck_ctrl_pkg::*;
#(
   parameter int unsigned MIN_ON_CYC  = 4,
   parameter int unsigned MIN_OFF_CYC = 12
) (
   input  logic   clk,
   input  logic   rst_n,
   input  lvl_e   lvl,
   input  logic   ready,
   output drive_e tgt,
   output logic   lvl_hi
);

   logic hi_ok;
   logic off_ok;
   logic hs_req;

   assign lvl_hi = (lvl == LVL_HI);

   // consecutive cycles at the high level
   bgc_satcnt #(.MAX(MIN_ON_CYC - 1), .RST_AT_MAX(1'b0)) u_hi_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!lvl_hi),
      .at_max (hi_ok)
   );

   // cycles since the high-side request ended
   bgc_satcnt #(.MAX(MIN_OFF_CYC - 1), .RST_AT_MAX(1'b1)) u_off_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hs_req),
      .at_max (off_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_req <= 1'b0;
      end else begin
         hs_req <= lvl_hi && (hs_req || (hi_ok && off_ok));
      end
   end

   always_comb begin
      if (!ready) begin
         tgt = DRV_OFF;
      end else if (hs_req) begin
         tgt = DRV_HI;
      end else if (lvl == LVL_LO) begin
         tgt = DRV_LO;
      end else begin
         tgt = DRV_OFF;
      end
   end

endmodule

// File: rtl/bgc_deadtime.sv
module bgc_deadtime
   import buck_ctrl_pkg::*;
#(
   parameter int unsigned DEAD_CYC = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  drive_e tgt,
   output logic   hs_on,
   output logic   ls_on
);

   logic idle_ok;

   bgc_satcnt #(.MAX(DEAD_CYC - 1), .RST_AT_MAX(1'b1)) u_idle_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hs_on || ls_on),
      .at_max (idle_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_on <= 1'b0;
         ls_on <= 1'b0;
      end else begin
         hs_on <= (tgt == DRV_HI) && (hs_on || (!ls_on && idle_ok));
         ls_on <= (tgt == DRV_LO) && (ls_on || (!hs_on && idle_ok));
      end
   end

endmodule

// File: rtl/bgc_fault.sv
module bgc_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   input  logic ot,
   input  logic oc,
   input  logic oc_en,
   input  logic lvl_hi,
   input  logic ls_gate,
   output logic fault_q,
   output logic set_evt
);

   logic ls_d;
   logic valley;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ls_d <= 1'b0;
      end else begin
         ls_d <= ls_gate;
      end
   end

   // low side just released for a new high pulse
   assign valley  = ls_d && !ls_gate && lvl_hi;
   assign set_evt = ot || (valley && oc && oc_en);

   // loss of validity dominates any set condition
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
      end else if (!ready) begin
         fault_q <= 1'b0;
      end else if (set_evt) begin
         fault_q <= 1'b1;
      end
   end

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
   import buck_ctrl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEAD_CYC    = 2,
   parameter int unsigned MIN_ON_CYC  = 10,
   parameter int unsigned MIN_OFF_CYC = 50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwm_code,
   input  logic       en_ok,
   input  logic       vcc_ok,
   input  logic       ot_flag,
   input  logic       oc_flag,
   input  logic       oc_en,
   output logic       hs_gate,
   output logic       ls_gate,
   output logic       fault
);

   localparam int unsigned NSYNC = 7;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end
   if (MIN_ON_CYC < DEAD_CYC) begin : g_bad_on
      $error("MIN_ON_CYC must not be below DEAD_CYC");
   end
   if (MIN_OFF_CYC < 1) begin : g_bad_off
      $error("MIN_OFF_CYC must be at least 1");
   end

   logic [NSYNC-1:0] raw_in;
   logic [NSYNC-1:0] syn;
   logic             ready;
   lvl_e             lvl;
   drive_e           tgt;
   logic             lvl_hi;
   logic             fault_set;

   assign raw_in = {pwm_code, en_ok, vcc_ok, ot_flag, oc_flag, oc_en};

   bgc_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign ready = syn[4] && syn[3];
   assign lvl   = decode_lvl(syn[6:5]);

   bgc_shaper #(.MIN_ON_CYC(MIN_ON_CYC), .MIN_OFF_CYC(MIN_OFF_CYC)) u_shaper (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl),
      .ready  (ready),
      .tgt    (tgt),
      .lvl_hi (lvl_hi)
   );

   bgc_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
      .clk   (clk),
      .rst_n (rst_n),
      .tgt   (tgt),
      .hs_on (hs_gate),
      .ls_on (ls_gate)
   );

   bgc_fault u_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready   (ready),
      .ot      (syn[2]),
      .oc      (syn[1]),
      .oc_en   (syn[0]),
      .lvl_hi  (lvl_hi),
      .ls_gate (ls_gate),
      .fault_q (fault),
      .set_evt (fault_set)
   );

endmodule

// File: rtl/buck_gate_ctrl_chk.sv
module buck_gate_ctrl_chk #(
   parameter int unsigned DEAD    = 2,
   parameter int unsigned MIN_OFF = 50
) (
   input logic clk,
   input logic rst_n,
   input logic rdy,
   input logic hs,
   input logic ls,
   input logic fault,
   input logic set_evt
);

   localparam logic [15:0] DEAD_L = 16'(DEAD);
   localparam logic [15:0] OFF_L  = 16'(MIN_OFF);

   logic [15:0] gap_q;
   logic [15:0] low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= 16'hFFFF;
         low_q <= 16'hFFFF;
      end else begin
         if (hs || ls) gap_q <= '0;
         else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
         if (hs) low_q <= '0;
         else if (low_q != 16'hFFFF) low_q <= low_q + 16'd1;
      end
   end

   // R3
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs && ls));

   // R3
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs) || $rose(ls)) |-> (gap_q >= DEAD_L));

   // R5
   min_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs) |-> (low_q >= OFF_L));

   // R2
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> (!hs && !ls));

   // R9
   fault_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> !fault);

   // R8
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && rdy) |=> fault);

   // R7
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(set_evt));

endmodule

bind buck_gate_ctrl buck_gate_ctrl_chk #(.DEAD(DEAD_CYC), .MIN_OFF(MIN_OFF_CYC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rdy     (ready),
   .hs      (hs_gate),
   .ls      (ls_gate),
   .fault   (fault),
   .set_evt (fault_set)
);

// File: tb/sim_buck_gate_ctrl.sv
`timescale 1ns/1ps
module sim_buck_gate_ctrl;

   localparam int DEAD    = 2;
   localparam int MIN_ON  = 4;
   localparam int MIN_OFF = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwm_code = 2'b01;
   logic       en_ok = 1'b0;
   logic       vcc_ok = 1'b0;
   logic       ot_flag = 1'b0;
   logic       oc_flag = 1'b0;
   logic       oc_en = 1'b0;
   logic       hs_gate;
   logic       ls_gate;
   logic       fault;

   int n_chk = 0;
   int n_fail = 0;
   int hs_acc = 0;
   bit done = 1'b0;

   // monitor state
   bit prev_hs = 1'b0;
   bit prev_ls = 1'b0;
   int off_both = 1000;
   int hs_low = 1000;
   int last_hs_gap = 0;
   int last_dead_hs = 0;
   int last_dead_ls = 0;
   int overlap_cnt = 0;
   int dead_bad = 0;

   always #2.5 clk = ~clk;

   buck_gate_ctrl #(
      .SYNC_STAGES (2),
      .DEAD_CYC    (DEAD),
      .MIN_ON_CYC  (MIN_ON),
      .MIN_OFF_CYC (MIN_OFF)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_code (pwm_code),
      .en_ok    (en_ok),
      .vcc_ok   (vcc_ok),
      .ot_flag  (ot_flag),
      .oc_flag  (oc_flag),
      .oc_en    (oc_en),
      .hs_gate  (hs_gate),
      .ls_gate  (ls_gate),
      .fault    (fault)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (hs_gate && ls_gate) overlap_cnt++;
         if (hs_gate && !prev_hs) begin
            last_hs_gap  = hs_low;
            last_dead_hs = off_both;
            if (off_both < DEAD) dead_bad++;
         end
         if (ls_gate && !prev_ls) begin
            last_dead_ls = off_both;
            if (off_both < DEAD) dead_bad++;
         end
         off_both = (hs_gate || ls_gate) ? 0 : off_both + 1;
         hs_low   = hs_gate ? 0 : hs_low + 1;
         prev_hs  = hs_gate;
         prev_ls  = ls_gate;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // apply a command for n cycles, counting high-side on cycles
   task automatic step(input logic [1:0] c, input int n);
      pwm_code = c;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (hs_gate) hs_acc++;
      end
   endtask

   function automatic int exp_hs(input int c);
      return (c == 2) ? 1 : 0;
   endfunction

   function automatic int exp_ls(input int c);
      return (c == 0) ? 1 : 0;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, R2: not valid yet
      chk("R2 reset hs", hs_gate, 0);
      chk("R2 reset ls", ls_gate, 0);
      chk("R9 reset fault", fault, 0);
      en_ok = 1'b1;
      vcc_ok = 1'b1;
      step(2'b01, 10);

      // R1: every pair of successive codes
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            step(2'(a), 30);
            step(2'(b), 30);
            chk($sformatf("R1 hs %0d->%0d", a, b), hs_gate, exp_hs(b));
            chk($sformatf("R1 ls %0d->%0d", a, b), ls_gate, exp_ls(b));
         end
      end

      // R3: dead gaps on both transitions
      step(2'b00, 30);
      step(2'b10, 30);
      chk("R3 gap before hs", last_dead_hs, MIN_ON);
      step(2'b00, 30);
      chk("R3 gap before ls", last_dead_ls, DEAD);

      // R4: pulse width sweep around the blanking limit
      for (int w = 1; w <= MIN_ON + 5; w++) begin
         step(2'b00, 30);
         hs_acc = 0;
         step(2'b10, w);
         step(2'b00, 30);
         chk($sformatf("R4 width %0d", w), hs_acc, (w < MIN_ON) ? 0 : w - MIN_ON + 1);
      end

      // R5: low gap sweep around the minimum off time
      for (int l = 1; l <= MIN_OFF + 3; l++) begin
         step(2'b00, 30);
         step(2'b10, 30);
         step(2'b00, l);
         step(2'b10, 30);
         chk($sformatf("R5 gap L=%0d", l), last_hs_gap, imax(l + MIN_ON - 1, MIN_OFF));
      end

      // R2: enable drop while high, latency of three edges
      step(2'b10, 30);
      en_ok = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R2 hs before sync", hs_gate, 1);
      @(negedge clk);
      chk("R2 hs off on enable loss", hs_gate, 0);
      step(2'b00, 20);
      chk("R2 ls held off", ls_gate, 0);
      en_ok = 1'b1;
      step(2'b00, 20);
      chk("R2 ls resumes", ls_gate, 1);
      vcc_ok = 1'b0;
      step(2'b00, 10);
      chk("R2 ls off on supply loss", ls_gate, 0);
      vcc_ok = 1'b1;
      step(2'b10, 30);
      chk("R2 hs resumes", hs_gate, 1);

      // R6: over-current without a valley does nothing
      oc_flag = 1'b1;
      oc_en = 1'b1;
      step(2'b00, 40);
      chk("R6 oc while low", fault, 0);
      step(2'b01, 20);
      step(2'b10, 20);
      chk("R6 oc after mid", fault, 0);
      // R7: disabled over-current
      oc_en = 1'b0;
      step(2'b00, 20);
      step(2'b10, 20);
      chk("R7 oc disabled", fault, 0);
      // R6: valley sample with enable
      oc_en = 1'b1;
      step(2'b00, 20);
      step(2'b10, 20);
      chk("R6 oc at valley", fault, 1);
      oc_flag = 1'b0;
      // R8: enable toggle does not clear
      oc_en = 1'b0;
      step(2'b10, 10);
      oc_en = 1'b1;
      step(2'b10, 10);
      chk("R8 sticky after oc_en toggle", fault, 1);

      // R10: switching unchanged with fault set
      step(2'b00, 30);
      hs_acc = 0;
      step(2'b10, 10);
      step(2'b00, 30);
      chk("R10 width with fault", hs_acc, 10 - MIN_ON + 1);
      chk("R10 fault kept", fault, 1);

      // R9: enable loss releases fault
      en_ok = 1'b0;
      step(2'b10, 4);
      chk("R9 fault released", fault, 0);
      en_ok = 1'b1;
      step(2'b10, 20);
      chk("R8 cleared stays clear", fault, 0);

      // R7: over-temperature with enable off
      oc_en = 1'b0;
      ot_flag = 1'b1;
      step(2'b01, 10);
      chk("R7 ot sets fault", fault, 1);
      ot_flag = 1'b0;
      step(2'b01, 10);
      chk("R8 ot fault holds", fault, 1);

      // R9: clear dominates a simultaneous set
      vcc_ok = 1'b0;
      step(2'b01, 6);
      chk("R9 supply loss clears", fault, 0);
      ot_flag = 1'b1;
      step(2'b01, 15);
      chk("R9 set blocked while invalid", fault, 0);
      vcc_ok = 1'b1;
      step(2'b01, 10);
      chk("R9 set again after return", fault, 1);
      ot_flag = 1'b0;

      // R3: monitor results over the whole run
      chk("R3 overlap cycles", overlap_cnt, 0);
      chk("R3 short dead gaps", dead_bad, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule